// File: doc/BRIEF.md
# Clustered Instruction Buffer Address Translator

This block serves one instruction cluster of a distributed loop buffer, in which each group of functional units owns a private partition of operation storage. While a loop body is being loaded, the block receives one fill word per loop slot. A real operation is written to the next free partition row. A NOP is written nowhere and is only marked as unused in a per-slot control table. The partition therefore holds only this cluster's real operations, packed densely from row 0, and its depth can differ from that of the other clusters.

During loop execution a shared loop counter supplies a loop-relative fetch address to every cluster. The block looks up the slot's usage bit and local row. It reads the partition only when the slot carries a real operation, and one cycle later it presents either that operation with a valid flag or the NOP code. A fetch address at or past the end of the loaded body raises an error flag and also yields a NOP. The branch cluster uses the same block: its partition holds the loop's branch operations and its own index entries.

Top module: `cfx_cluster_fetch`

## Requirements
- R1: After reset the loaded length is zero. `op_valid` and `addr_err` are low and `op_out` equals the NOP code. Any fetch before a fill completes is out of range.
- R2: Each accepted fill word takes the next loop slot, starting at slot 0. A word that differs from the NOP code (default all zeros) is stored in the next partition row, starting at row 0. A NOP word uses no row, so the rows of real operations are dense.
- R3: A fetch to an in-range slot that holds an operation raises `part_rd_en` in the same cycle. On the next cycle `op_valid` is 1 and `op_out` equals the operation filled into that slot.
- R4: A fetch to an in-range NOP slot keeps `part_rd_en` low. On the next cycle `op_valid` and `addr_err` are 0 and `op_out` is the NOP code.
- R5: A fetch whose address is not below the loaded length keeps `part_rd_en` low. On the next cycle `addr_err` is 1, `op_valid` is 0 and `op_out` is the NOP code.
- R6: In a cycle with `fetch_en` low, `part_rd_en` is low. On the next cycle `op_valid` and `addr_err` are 0 and `op_out` is the NOP code.
- R7: `fill_start` resets the loaded length and the row count to zero. A `fill_valid` word presented in the same cycle is ignored.
- R8: If a fill word does not fit, it is ignored. This happens when the table already holds LOOP_DEPTH slots, or when the word is an operation and all PART_DEPTH rows are used. Every later fill word is also ignored until the next `fill_start`, so fetches to those slots report R5 errors. An operation that uses the last free row is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_start | input | 1 | Begin loading a new loop body |
| fill_valid | input | 1 | A fill word is presented this cycle |
| fill_op | input | OP_W | Operation for the next loop slot, or the NOP code |
| fetch_en | input | 1 | A loop-relative fetch is requested |
| fetch_addr | input | $clog2(LOOP_DEPTH) | Loop-relative slot address |
| part_rd_en | output | 1 | Partition read strobe for this fetch (combinational) |
| op_out | output | OP_W | Operation issued to the cluster, NOP code when idle |
| op_valid | output | 1 | A real operation is issued this cycle |
| addr_err | output | 1 | Previous fetch addressed a slot past the loaded length |

## Verification
The main lookup is exercised with a mixed body of operations and NOP slots. This body is walked in order, backwards and with branch-like jumps, so a row assignment that is off by one, or that counts NOP slots, would return a wrong operation. An all-NOP body separates read gating from range checking. Fetches just past the loaded length, a fill that overflows the partition and a fill that exactly fills both storages separate the acceptance boundary from the sealing rule. A fill start coinciding with a fill word shows whether that word leaks into slot 0.

// File: rtl/cfx_pkg.sv
// Shared types and helpers for the clustered fetch translator.
// Assumes nothing beyond standard SystemVerilog.
package cfx_pkg;

    // Registered outcome of one fetch lookup
    typedef struct packed {
        logic issue;
        logic err;
    } cfx_meta_t;

    // Address width for a storage of n entries, never below one bit
    function automatic int unsigned cfx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cfx_fill_seq.sv
// Fill sequencer: assigns loop slots and dense partition rows to incoming
// fill words. NOP words consume a slot but no row. Once a word does not fit,
// the fill is sealed until the next fill_start.
// Assumes fill_start and fill_valid come from the loop controller only.
module cfx_fill_seq #(
    parameter int unsigned LOOP_DEPTH = 32,
    parameter int unsigned PART_DEPTH = 16,
    parameter int unsigned OP_W       = 16,
    parameter logic [OP_W-1:0] NOP_CODE = '0,
    parameter int unsigned AW = 5,
    parameter int unsigned IW = 4,
    parameter int unsigned LW = 6,
    parameter int unsigned RW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_start,
    input  logic            fill_valid,
    input  logic [OP_W-1:0] fill_op,
    output logic            tbl_we,
    output logic [AW-1:0]   tbl_waddr,
    output logic            tbl_used,
    output logic [IW-1:0]   tbl_row,
    output logic            part_we,
    output logic [IW-1:0]   part_waddr,
    output logic [OP_W-1:0] part_wdata,
    output logic [LW-1:0]   fill_len
);

    logic [LW-1:0] len_q;
    logic [RW-1:0] rows_q;
    logic          sealed_q;
    logic          is_op;
    logic          room_tbl;
    logic          room_part;
    logic          offered;
    logic          accept;
    logic          reject;

    // Decide whether the presented word fits in table and partition
    always_comb begin
        is_op     = (fill_op != NOP_CODE);
        room_tbl  = (len_q < LW'(LOOP_DEPTH));
        room_part = (rows_q < RW'(PART_DEPTH));
        offered   = fill_valid && !fill_start && !sealed_q;
        accept    = offered && room_tbl && (!is_op || room_part);
        reject    = offered && !accept;
    end

    // Track loaded length, used rows and the sealed condition
    always_ff @(posedge clk) begin
        if (!rst_n || fill_start) begin
            len_q    <= '0;
            rows_q   <= '0;
            sealed_q <= 1'b0;
        end else begin
            if (accept) begin
                len_q <= len_q + LW'(1);
            end
            if (accept && is_op) begin
                rows_q <= rows_q + RW'(1);
            end
            if (reject) begin
                sealed_q <= 1'b1;
            end
        end
    end

    // Drive the table and partition write ports for an accepted word
    always_comb begin
        tbl_we     = accept;
        tbl_waddr  = len_q[AW-1:0];
        tbl_used   = is_op;
        tbl_row    = is_op ? rows_q[IW-1:0] : '0;
        part_we    = accept && is_op;
        part_waddr = rows_q[IW-1:0];
        part_wdata = fill_op;
        fill_len   = len_q;
    end

endmodule

// File: rtl/cfx_ctrl_table.sv
// Per-slot control table: one usage bit and one local row index per loop
// slot. It resolves a fetch address into a gated read request or a range miss.
// Assumes fill_len never exceeds LOOP_DEPTH.
module cfx_ctrl_table #(
    parameter int unsigned LOOP_DEPTH = 32,
    parameter int unsigned AW = 5,
    parameter int unsigned IW = 4,
    parameter int unsigned LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wused,
    input  logic [IW-1:0] wrow,
    input  logic [LW-1:0] fill_len,
    input  logic          fetch_en,
    input  logic [AW-1:0] fetch_addr,
    output logic          rd_hit,
    output logic          range_miss,
    output logic [IW-1:0] rd_row
);

    logic [LOOP_DEPTH-1:0] used_vec;
    logic [IW-1:0]         row_arr [LOOP_DEPTH];
    logic                  in_range;

    for (genvar a = 0; a < LOOP_DEPTH; a++) begin : g_slot
        logic          used_r;
        logic [IW-1:0] row_r;

        // Usage bit of this slot, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_r <= 1'b0;
            end else if (we && (waddr == AW'(a))) begin
                used_r <= wused;
            end
        end

        // Local row of this slot, meaningful only when the usage bit is set
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(a))) begin
                row_r <= wrow;
            end
        end

        assign used_vec[a] = used_r;
        assign row_arr[a]  = row_r;
    end

    // Resolve the fetch address against the loaded length and usage bit
    always_comb begin
        in_range   = (LW'(fetch_addr) < fill_len);
        rd_hit     = fetch_en && in_range && used_vec[fetch_addr];
        range_miss = fetch_en && !in_range;
        rd_row     = row_arr[fetch_addr];
    end

endmodule

// File: rtl/cfx_partition.sv
// Operation partition of one cluster: synchronous write and registered read.
// Read only when re is set, so idle slots cost no array access.
// Assumes no write and read to the same row in one cycle.
module cfx_partition #(
    parameter int unsigned PART_DEPTH = 16,
    parameter int unsigned IW   = 4,
    parameter int unsigned OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   waddr,
    input  logic [OP_W-1:0] wdata,
    input  logic            re,
    input  logic [IW-1:0]   raddr,
    output logic [OP_W-1:0] rdata
);

    logic [OP_W-1:0] mem [PART_DEPTH];
    logic [OP_W-1:0] rdata_q;

    // Store a filled operation
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read, performed only when requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/cfx_issue_stage.sv
// Issue stage: registers the lookup outcome beside the partition read and
// substitutes the NOP code whenever no real operation is issued.
// Assumes part_rdata is the read data registered in the same edge.
module cfx_issue_stage #(
    parameter int unsigned OP_W = 16,
    parameter logic [OP_W-1:0] NOP_CODE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_hit,
    input  logic            range_miss,
    input  logic [OP_W-1:0] part_rdata,
    output logic [OP_W-1:0] op_out,
    output logic            op_valid,
    output logic            addr_err
);

    cfx_pkg::cfx_meta_t meta_q;

    // Capture the lookup outcome aligned with the partition read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else begin
            meta_q.issue <= rd_hit;
            meta_q.err   <= range_miss;
        end
    end

    // Select the stored operation or the NOP code
    always_comb begin
        op_valid = meta_q.issue;
        addr_err = meta_q.err;
        op_out   = meta_q.issue ? part_rdata : NOP_CODE;
    end

endmodule

// File: rtl/cfx_cluster_fetch.sv
// Top of the clustered fetch translator for one instruction cluster.
// Loads a loop body into a compressed partition plus per-slot control table,
// then translates loop-relative fetch addresses into gated partition reads.
// Assumes fill and fetch phases are sequenced by an external loop controller.
module cfx_cluster_fetch #(
    parameter int unsigned LOOP_DEPTH = 32,
    parameter int unsigned PART_DEPTH = 16,
    parameter int unsigned OP_W       = 16,
    parameter logic [OP_W-1:0] NOP_CODE = '0,
    localparam int unsigned AW = cfx_pkg::cfx_bits(LOOP_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_start,
    input  logic            fill_valid,
    input  logic [OP_W-1:0] fill_op,
    input  logic            fetch_en,
    input  logic [AW-1:0]   fetch_addr,
    output logic            part_rd_en,
    output logic [OP_W-1:0] op_out,
    output logic            op_valid,
    output logic            addr_err
);

    localparam int unsigned IW = cfx_pkg::cfx_bits(PART_DEPTH);
    localparam int unsigned LW = $clog2(LOOP_DEPTH + 1);
    localparam int unsigned RW = $clog2(PART_DEPTH + 1);

    logic            tbl_we;
    logic [AW-1:0]   tbl_waddr;
    logic            tbl_used;
    logic [IW-1:0]   tbl_row;
    logic            part_we;
    logic [IW-1:0]   part_waddr;
    logic [OP_W-1:0] part_wdata;
    logic [LW-1:0]   fill_len;
    logic            rd_hit;
    logic            range_miss;
    logic [IW-1:0]   rd_row;
    logic [OP_W-1:0] part_rdata;

    cfx_fill_seq #(
        .LOOP_DEPTH(LOOP_DEPTH), .PART_DEPTH(PART_DEPTH), .OP_W(OP_W),
        .NOP_CODE(NOP_CODE), .AW(AW), .IW(IW), .LW(LW), .RW(RW)
    ) u_fill (
        .clk(clk), .rst_n(rst_n),
        .fill_start(fill_start), .fill_valid(fill_valid), .fill_op(fill_op),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_used(tbl_used),
        .tbl_row(tbl_row), .part_we(part_we), .part_waddr(part_waddr),
        .part_wdata(part_wdata), .fill_len(fill_len)
    );

    cfx_ctrl_table #(
        .LOOP_DEPTH(LOOP_DEPTH), .AW(AW), .IW(IW), .LW(LW)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .waddr(tbl_waddr), .wused(tbl_used), .wrow(tbl_row),
        .fill_len(fill_len), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .rd_hit(rd_hit), .range_miss(range_miss), .rd_row(rd_row)
    );

    cfx_partition #(
        .PART_DEPTH(PART_DEPTH), .IW(IW), .OP_W(OP_W)
    ) u_part (
        .clk(clk), .rst_n(rst_n),
        .we(part_we), .waddr(part_waddr), .wdata(part_wdata),
        .re(rd_hit), .raddr(rd_row), .rdata(part_rdata)
    );

    cfx_issue_stage #(
        .OP_W(OP_W), .NOP_CODE(NOP_CODE)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .rd_hit(rd_hit), .range_miss(range_miss), .part_rdata(part_rdata),
        .op_out(op_out), .op_valid(op_valid), .addr_err(addr_err)
    );

    assign part_rd_en = rd_hit;

endmodule

// File: rtl/cfx_cluster_fetch_chk.sv
// Checker for the clustered fetch translator, attached by bind.
// Observes only the top-level ports.
module cfx_cluster_fetch_chk #(
    parameter int unsigned OP_W = 16,
    parameter logic [OP_W-1:0] NOP_CODE = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_en,
    input logic            part_rd_en,
    input logic [OP_W-1:0] op_out,
    input logic            op_valid,
    input logic            addr_err
);

    // A partition read only happens for a requested fetch
    assert_read_needs_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        part_rd_en |-> fetch_en);

    // A partition read issues a valid operation one cycle later
    assert_issue_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        part_rd_en |=> op_valid);

    // No read means nothing is issued in the next cycle
    assert_no_read_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !part_rd_en |=> !op_valid);

    // A range error never comes with an issued operation
    assert_err_gives_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!op_valid && (op_out == NOP_CODE)));

    // An idle cycle leaves the outputs quiet afterwards
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> (!op_valid && !addr_err && (op_out == NOP_CODE)));

endmodule

bind cfx_cluster_fetch cfx_cluster_fetch_chk #(
    .OP_W(OP_W), .NOP_CODE(NOP_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .part_rd_en(part_rd_en),
    .op_out(op_out), .op_valid(op_valid), .addr_err(addr_err)
);

// File: tb/cfx_cluster_fetch_tb.sv
// Scoreboard bench: driver tasks push expected outcomes, a monitor pops and
// compares them one clock after each fetch.
module cfx_cluster_fetch_tb;

    localparam int LOOP_DEPTH = 32;
    localparam int PART_DEPTH = 16;
    localparam int OP_W = 16;
    localparam logic [OP_W-1:0] NOP = '0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fill_start = 1'b0;
    logic            fill_valid = 1'b0;
    logic [OP_W-1:0] fill_op = '0;
    logic            fetch_en = 1'b0;
    logic [4:0]      fetch_addr = '0;
    logic            part_rd_en;
    logic [OP_W-1:0] op_out;
    logic            op_valid;
    logic            addr_err;

    typedef struct {
        logic            v;
        logic            e;
        logic [OP_W-1:0] op;
        string           req;
    } exp_t;

    exp_t            sb[$];
    logic [OP_W-1:0] m_op [LOOP_DEPTH];
    int              m_len = 0;
    int              m_rows = 0;
    bit              m_sealed = 0;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 0;

    always #2 clk = ~clk;

    cfx_cluster_fetch #(
        .LOOP_DEPTH(LOOP_DEPTH), .PART_DEPTH(PART_DEPTH), .OP_W(OP_W), .NOP_CODE(NOP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_valid(fill_valid),
        .fill_op(fill_op), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .part_rd_en(part_rd_en), .op_out(op_out), .op_valid(op_valid), .addr_err(addr_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic start_fill(input bit with_word, input logic [OP_W-1:0] op);
        @(negedge clk);
        fill_start = 1'b1; fill_valid = with_word; fill_op = op; fetch_en = 1'b0;
        m_len = 0; m_rows = 0; m_sealed = 0;
    endtask

    task automatic fill_word(input logic [OP_W-1:0] op);
        @(negedge clk);
        fill_start = 1'b0; fill_valid = 1'b1; fill_op = op; fetch_en = 1'b0;
        if (!m_sealed && m_len < LOOP_DEPTH && (op == NOP || m_rows < PART_DEPTH)) begin
            m_op[m_len] = op;
            m_len++;
            if (op != NOP) m_rows++;
        end else begin
            m_sealed = 1;
        end
    endtask

    task automatic fetch(input int addr, input string req);
        exp_t e;
        @(negedge clk);
        fill_start = 1'b0; fill_valid = 1'b0; fetch_en = 1'b1; fetch_addr = 5'(addr);
        e.req = req;
        if (addr >= m_len) begin
            e.v = 0; e.e = 1; e.op = NOP;
        end else if (m_op[addr] == NOP) begin
            e.v = 0; e.e = 0; e.op = NOP;
        end else begin
            e.v = 1; e.e = 0; e.op = m_op[addr];
        end
        sb.push_back(e);
        #1;
        check(part_rd_en == e.v, req, "part_rd_en", 32'(part_rd_en), 32'(e.v));
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        fill_start = 1'b0; fill_valid = 1'b0; fetch_en = 1'b0;
        e.v = 0; e.e = 0; e.op = NOP; e.req = "R6";
        sb.push_back(e);
        #1;
        check(!part_rd_en, "R6", "part_rd_en idle", 32'(part_rd_en), 32'd0);
    endtask

    // Monitor: compare registered outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(op_valid === e.v, e.req, "op_valid", 32'(op_valid), 32'(e.v));
                check(addr_err === e.e, e.req, "addr_err", 32'(addr_err), 32'(e.e));
                check(op_out === e.op, e.req, "op_out", 32'(op_out), 32'(e.op));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(!op_valid && !addr_err && op_out == NOP, "R1", "reset outputs",
              {op_out, 14'd0, op_valid, addr_err}, 32'd0);
        fetch(0, "R1");

        // R2 R3 R4: mixed body, rows dense over operations only
        start_fill(0, NOP);
        fill_word(16'h1111); fill_word(NOP); fill_word(16'h2222); fill_word(16'h3333);
        fill_word(NOP); fill_word(NOP); fill_word(16'h4444); fill_word(16'h5555);
        for (int i = 0; i < 8; i++) fetch(i, "R2/R3/R4");
        fetch(7, "R2"); fetch(6, "R2"); fetch(0, "R3"); fetch(3, "R2"); fetch(1, "R4");
        fetch(2, "R3");
        idle(); idle();
        fetch(5, "R4");
        // R5: just past the end and far past
        fetch(8, "R5"); fetch(31, "R5"); fetch(7, "R3");

        // R7: word in the fill_start cycle is ignored
        start_fill(1, 16'h7777);
        fetch(0, "R7");
        fill_word(16'h9999);
        fetch(0, "R7"); fetch(1, "R7");

        // R8: partition overflow seals the fill
        start_fill(0, NOP);
        for (int i = 0; i < 18; i++) fill_word(16'h0100 + 16'(i));
        fill_word(NOP);
        fetch(15, "R8"); fetch(16, "R8"); fetch(17, "R8"); fetch(18, "R8"); fetch(0, "R8");

        // R8 boundary: exactly 16 operations and 32 slots, then one more word
        start_fill(0, NOP);
        for (int i = 0; i < 32; i++) fill_word((i % 2 == 0) ? 16'hA000 + 16'(i) : NOP);
        fill_word(16'hBEEF);
        fetch(30, "R8"); fetch(31, "R8"); fetch(0, "R8"); fetch(16, "R8");

        // R4 R5: body of NOPs only
        start_fill(0, NOP);
        fill_word(NOP); fill_word(NOP); fill_word(NOP);
        fetch(0, "R4"); fetch(2, "R4"); fetch(3, "R5");
        idle(); idle(); idle();

        @(negedge clk);
        fetch_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule